// File: doc/BRIEF.md
# Variable-Length Instruction Field Splitter

The block takes an instruction byte stream, one byte per cycle, and cuts each instruction into its fields. The fields are the prefix bytes sorted into four groups, one or two opcode bytes, the optional addressing-form byte, the optional scale-index byte, the displacement and the immediate. When the last byte of an instruction has been taken, the block raises `done` for one cycle. In that cycle it reports the total byte count and holds every field.

A mode pin sets the default addressing width. A low value selects 16-bit rules and a high value selects 32-bit rules. The address-size prefix flips that width for the current instruction only. The width decides whether a scale-index byte follows and how many displacement bytes come after it. The block does not decode opcodes. Upstream logic drives a class code together with the final opcode byte. The class code says whether an addressing-form byte follows and how many immediate bytes there are.

The input is valid/ready. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. Upstream must hold `in_byte` steady while `in_valid` is high and the byte has not yet been taken. Gaps with `in_valid` low are allowed at any point. The block never applies back-pressure once it is out of reset, so each byte costs exactly one cycle. The results are plain pins and are valid in the `done` cycle. They stay unchanged until the first byte of the next instruction is taken.

Top module: `insn_splitter`

## Requirements
- R1: Prefix bytes are sorted into four groups, in any order. Group 1 (lock/repeat) is F0, F2 or F3 and is reported on `rep_lock`. Group 2 (segment) is 2E, 36, 3E, 26, 64 or 65 and is reported on `seg_ovr`. Group 3 is 66 and sets `opsz_ovr`. Group 4 is 67 and sets `adsz_ovr`. A group that is absent reads 00 or 0.
- R2: A second prefix from a group that already holds one sets `dup_err` for that instruction. Parsing continues, and the group reports the byte that arrived last.
- R3: The byte 0F after the prefixes is an escape and sets `escaped`. One more opcode byte follows it. `opcode` reads {0F, second byte} when the escape is present and {00, opcode} when it is not.
- R4: If the byte just before the escape is F2, F3 or 66, that byte is reported on `mand_pfx` and is removed from its group field. `mand_pfx` reads 00 otherwise.
- R5: The class inputs are sampled with the final opcode byte. `cls_has_form` says an addressing-form byte follows. `cls_imm_code` encodes the immediate size: 0 means none, 1 means 1 byte, 2 means 2 bytes and 3 means 4 bytes. `imm_len` reports 0, 1, 2 or 4.
- R6: In the addressing-form byte, bits 7:6 are mod, bits 5:3 are reg and bits 2:0 are r/m. A mod of 11 selects a register operand, with no displacement and no scale-index byte.
- R7: Under 32-bit rules with mod not 11, an r/m of 100 means a scale-index byte follows. The displacement length is 1 for mod 01 and 4 for mod 10. For mod 00 it is 4 when r/m is 101 and 0 otherwise.
- R8: Under 32-bit rules with mod 00 and a scale-index byte whose bits 2:0 are 101, a 4-byte displacement follows.
- R9: Under 16-bit rules there is never a scale-index byte. The displacement length is 1 for mod 01 and 2 for mod 10. For mod 00 it is 2 when r/m is 110 and 0 otherwise.
- R10: The effective addressing width is the mode pin XOR `adsz_ovr`. The flip applies to the current instruction only.
- R11: Displacement bytes come after the form byte, or after the scale-index byte when one is present. Immediate bytes come after any displacement. Each value is assembled little-endian: the first byte received is the least significant. Bytes that were not received read zero.
- R12: `done` is high for exactly the one cycle after the edge that takes the last byte. In that cycle `total_len` equals the number of bytes in the instruction.
- R13: When a 16th byte of one instruction is taken, `abort` pulses for one cycle and `done` does not rise. Parsing restarts at the prefix stage, and the next byte begins a fresh instruction.
- R14: `in_ready` is high in every cycle after reset is released. With `in_valid` low, no byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Stream byte |
| addr32_mode | input | 1 | Default addressing width, 1 = 32-bit |
| cls_has_form | input | 1 | Class: addressing-form byte follows the opcode |
| cls_imm_code | input | 2 | Class: immediate size code |
| done | output | 1 | Instruction complete pulse |
| abort | output | 1 | Length overrun pulse |
| dup_err | output | 1 | Repeated prefix group seen |
| total_len | output | 4 | Instruction length in bytes |
| rep_lock | output | 8 | Group 1 prefix or 00 |
| seg_ovr | output | 8 | Group 2 prefix or 00 |
| opsz_ovr | output | 1 | Operand-size prefix present |
| adsz_ovr | output | 1 | Address-size prefix present |
| mand_pfx | output | 8 | Mandatory prefix or 00 |
| escaped | output | 1 | Two-byte opcode |
| opcode | output | 16 | Opcode bytes |
| form_vld | output | 1 | Addressing-form byte present |
| form_byte | output | 8 | Addressing-form byte |
| sib_vld | output | 1 | Scale-index byte present |
| sib_byte | output | 8 | Scale-index byte |
| disp_len | output | 3 | Displacement length in bytes |
| disp_val | output | 32 | Displacement value |
| imm_len | output | 3 | Immediate length in bytes |
| imm_val | output | 32 | Immediate value |

## Verification
Two functions can fall in the same cycle. One is the `done` report of an instruction. The other is the taking of the first byte of the next instruction, which clears every field at the next edge. The bench often sends instructions back to back with no idle cycle. In those cases the first new byte is already on `in_byte` with `in_valid` high while the bench reads the old instruction's fields in the `done` cycle. Every field must still match the finished instruction, and the following instruction must come out intact with no leftover prefix, form, displacement or error state.

// File: rtl/insn_split_pkg.sv
package insn_split_pkg;

  localparam logic [7:0] ESC_BYTE = 8'h0F;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_LOCKREP,
    PG_SEG,
    PG_OPSZ,
    PG_ADSZ
  } pfx_grp_e;

  typedef enum logic [2:0] {
    ST_PFX,
    ST_OP2,
    ST_FORM,
    ST_SIB,
    ST_DISP,
    ST_IMM
  } split_st_e;

  function automatic pfx_grp_e pfx_group(input logic [7:0] b);
    unique case (b)
      8'hF0, 8'hF2, 8'hF3:                      pfx_group = PG_LOCKREP;
      8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: pfx_group = PG_SEG;
      8'h66:                                    pfx_group = PG_OPSZ;
      8'h67:                                    pfx_group = PG_ADSZ;
      default:                                  pfx_group = PG_NONE;
    endcase
  endfunction

  function automatic logic [2:0] imm_bytes(input logic [1:0] code);
    unique case (code)
      2'd0:    imm_bytes = 3'd0;
      2'd1:    imm_bytes = 3'd1;
      2'd2:    imm_bytes = 3'd2;
      default: imm_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/isp_pfx_tracker.sv
module isp_pfx_tracker
  import insn_split_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fresh,
  input  logic       pfx_we,
  input  logic       esc_we,
  input  logic [7:0] in_byte,
  output logic [7:0] rep_lock,
  output logic [7:0] seg_ovr,
  output logic       opsz_ovr,
  output logic       adsz_ovr,
  output logic [7:0] mand_pfx,
  output logic       dup_err
);

  logic [7:0] g1_q, g2_q, mand_q, last_q;
  logic       g3_q, g4_q, dup_q;
  logic [7:0] b_g1, b_g2, b_last;
  logic       b_g3, b_g4, b_dup;

  // A new instruction starts from an empty prefix set.
  always_comb begin
    b_g1   = fresh ? 8'h00 : g1_q;
    b_g2   = fresh ? 8'h00 : g2_q;
    b_g3   = fresh ? 1'b0  : g3_q;
    b_g4   = fresh ? 1'b0  : g4_q;
    b_dup  = fresh ? 1'b0  : dup_q;
    b_last = fresh ? 8'h00 : last_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g1_q <= '0; g2_q <= '0; g3_q <= 1'b0; g4_q <= 1'b0;
      dup_q <= 1'b0; mand_q <= '0; last_q <= '0;
    end else if (fresh || pfx_we || esc_we) begin
      g1_q   <= b_g1;
      g2_q   <= b_g2;
      g3_q   <= b_g3;
      g4_q   <= b_g4;
      dup_q  <= b_dup;
      mand_q <= fresh ? 8'h00 : mand_q;
      last_q <= 8'h00;
      if (pfx_we) begin
        last_q <= in_byte;
        unique case (pfx_group(in_byte))
          PG_LOCKREP: begin g1_q <= in_byte; if (b_g1 != 8'h00) dup_q <= 1'b1; end
          PG_SEG:     begin g2_q <= in_byte; if (b_g2 != 8'h00) dup_q <= 1'b1; end
          PG_OPSZ:    begin g3_q <= 1'b1;    if (b_g3) dup_q <= 1'b1; end
          PG_ADSZ:    begin g4_q <= 1'b1;    if (b_g4) dup_q <= 1'b1; end
          default:    ;
        endcase
      end
      if (esc_we) begin
        if (b_last == 8'hF2 || b_last == 8'hF3) begin
          mand_q <= b_last;
          g1_q   <= 8'h00;
        end else if (b_last == 8'h66) begin
          mand_q <= b_last;
          g3_q   <= 1'b0;
        end
      end
    end
  end

  assign rep_lock = g1_q;
  assign seg_ovr  = g2_q;
  assign opsz_ovr = g3_q;
  assign adsz_ovr = g4_q;
  assign mand_pfx = mand_q;
  assign dup_err  = dup_q;

endmodule

// File: rtl/isp_form_rules.sv
module isp_form_rules (
  input  logic [1:0] mod_f,
  input  logic [2:0] rm_f,
  input  logic [2:0] base_f,
  input  logic       wide,
  output logic       sib_next,
  output logic [2:0] disp_bytes
);

  always_comb begin
    sib_next   = 1'b0;
    disp_bytes = 3'd0;
    if (mod_f != 2'b11) begin
      if (wide) begin
        sib_next = (rm_f == 3'b100);
        unique case (mod_f)
          2'b00:   disp_bytes = (rm_f == 3'b101 || (rm_f == 3'b100 && base_f == 3'b101)) ? 3'd4 : 3'd0;
          2'b01:   disp_bytes = 3'd1;
          default: disp_bytes = 3'd4;
        endcase
      end else begin
        unique case (mod_f)
          2'b00:   disp_bytes = (rm_f == 3'b110) ? 3'd2 : 3'd0;
          2'b01:   disp_bytes = 3'd1;
          default: disp_bytes = 3'd2;
        endcase
      end
    end
  end

endmodule

// File: rtl/isp_le_collector.sv
module isp_le_collector #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [7:0]            din,
  output logic [8*NBYTES-1:0]   value
);

  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_q <= '0;
    else if (we)       idx_q <= idx_q + IW'(1);
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                lane_q <= 8'h00;
      else if (we && idx_q == IW'(i))   lane_q <= din;
    end
    assign value[8*i +: 8] = lane_q;
  end

endmodule

// File: rtl/insn_splitter.sv
module insn_splitter
  import insn_split_pkg::*;
#(
  parameter int MAX_LEN    = 15,
  parameter int DISP_BYTES = 4,
  parameter int IMM_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_byte,
  input  logic                    addr32_mode,
  input  logic                    cls_has_form,
  input  logic [1:0]              cls_imm_code,
  output logic                    done,
  output logic                    abort,
  output logic                    dup_err,
  output logic [3:0]              total_len,
  output logic [7:0]              rep_lock,
  output logic [7:0]              seg_ovr,
  output logic                    opsz_ovr,
  output logic                    adsz_ovr,
  output logic [7:0]              mand_pfx,
  output logic                    escaped,
  output logic [15:0]             opcode,
  output logic                    form_vld,
  output logic [7:0]              form_byte,
  output logic                    sib_vld,
  output logic [7:0]              sib_byte,
  output logic [2:0]              disp_len,
  output logic [8*DISP_BYTES-1:0] disp_val,
  output logic [2:0]              imm_len,
  output logic [8*IMM_BYTES-1:0]  imm_val
);

  localparam int LW = $clog2(MAX_LEN + 1);

  split_st_e  state_q, nxt_state;
  logic [2:0] rem_q, nxt_rem;
  logic [LW-1:0] len_q;
  logic       start_q, rdy_q, done_q, abort_q;
  logic       esc_q, fvld_q, svld_q;
  logic [15:0] op_q;
  logic [7:0] form_q, sib_q;
  logic [2:0] dlen_q, ilen_q;

  logic accept, is_pfx, is_esc, over, fresh, finish;
  logic pfx_we, esc_we;
  logic op_last, addr_last, disp_last, imm_last;
  logic [7:0] fm_byte;
  logic sib_next;
  logic [2:0] dl, cls_ilen;

  assign accept   = in_valid && rdy_q;
  assign is_pfx   = (pfx_group(in_byte) != PG_NONE);
  assign is_esc   = (in_byte == ESC_BYTE);
  assign over     = accept && !start_q && (len_q == LW'(MAX_LEN));
  assign fresh    = accept && start_q;
  assign cls_ilen = imm_bytes(cls_imm_code);

  assign pfx_we = accept && !over && state_q == ST_PFX && is_pfx;
  assign esc_we = accept && !over && state_q == ST_PFX && !is_pfx && is_esc;

  isp_pfx_tracker u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fresh    (fresh),
    .pfx_we   (pfx_we),
    .esc_we   (esc_we),
    .in_byte  (in_byte),
    .rep_lock (rep_lock),
    .seg_ovr  (seg_ovr),
    .opsz_ovr (opsz_ovr),
    .adsz_ovr (adsz_ovr),
    .mand_pfx (mand_pfx),
    .dup_err  (dup_err)
  );

  // One rule decoder serves both the form stage and the scale-index stage.
  assign fm_byte = (state_q == ST_FORM) ? in_byte : form_q;

  isp_form_rules u_rules (
    .mod_f      (fm_byte[7:6]),
    .rm_f       (fm_byte[2:0]),
    .base_f     (in_byte[2:0]),
    .wide       (addr32_mode ^ adsz_ovr),
    .sib_next   (sib_next),
    .disp_bytes (dl)
  );

  assign op_last   = accept && ((state_q == ST_PFX && !is_pfx && !is_esc) || state_q == ST_OP2);
  assign addr_last = accept && ((state_q == ST_FORM && !sib_next) || state_q == ST_SIB);
  assign disp_last = accept && state_q == ST_DISP && rem_q == 3'd1;
  assign imm_last  = accept && state_q == ST_IMM  && rem_q == 3'd1;

  always_comb begin
    nxt_state = state_q;
    nxt_rem   = rem_q;
    finish    = 1'b0;
    if (accept) begin
      if (state_q == ST_PFX && !is_pfx && is_esc) nxt_state = ST_OP2;
      if (state_q == ST_FORM && sib_next)          nxt_state = ST_SIB;
      if ((state_q == ST_DISP || state_q == ST_IMM) && rem_q != 3'd1) nxt_rem = rem_q - 3'd1;
      if (op_last) begin
        if (cls_has_form)         nxt_state = ST_FORM;
        else if (cls_ilen != 3'd0) begin nxt_state = ST_IMM; nxt_rem = cls_ilen; end
        else                      finish = 1'b1;
      end
      if (addr_last) begin
        if (dl != 3'd0)           begin nxt_state = ST_DISP; nxt_rem = dl; end
        else if (ilen_q != 3'd0)  begin nxt_state = ST_IMM;  nxt_rem = ilen_q; end
        else                      finish = 1'b1;
      end
      if (disp_last) begin
        if (ilen_q != 3'd0)       begin nxt_state = ST_IMM; nxt_rem = ilen_q; end
        else                      finish = 1'b1;
      end
      if (imm_last) finish = 1'b1;
      if (finish) nxt_state = ST_PFX;
      if (over) begin
        nxt_state = ST_PFX;
        finish    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PFX;
      rem_q   <= '0;
      len_q   <= '0;
      start_q <= 1'b1;
      rdy_q   <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      esc_q   <= 1'b0;
      op_q    <= '0;
      fvld_q  <= 1'b0;
      form_q  <= '0;
      svld_q  <= 1'b0;
      sib_q   <= '0;
      dlen_q  <= '0;
      ilen_q  <= '0;
    end else begin
      rdy_q   <= 1'b1;
      done_q  <= finish;
      abort_q <= over;
      state_q <= nxt_state;
      rem_q   <= nxt_rem;
      if (accept) begin
        start_q <= finish || over;
        if (over)         len_q <= '0;
        else if (start_q) len_q <= LW'(1);
        else              len_q <= len_q + LW'(1);
      end
      if (fresh) begin
        esc_q  <= 1'b0;
        op_q   <= '0;
        fvld_q <= 1'b0;
        form_q <= '0;
        svld_q <= 1'b0;
        sib_q  <= '0;
        dlen_q <= '0;
        ilen_q <= '0;
      end
      if (accept && !over) begin
        if (state_q == ST_PFX && !is_pfx && is_esc) begin
          esc_q       <= 1'b1;
          op_q[15:8]  <= ESC_BYTE;
        end
        if (op_last) begin
          op_q[7:0] <= in_byte;
          ilen_q    <= cls_ilen;
        end
        if (state_q == ST_FORM) begin
          fvld_q <= 1'b1;
          form_q <= in_byte;
          if (!sib_next) dlen_q <= dl;
        end
        if (state_q == ST_SIB) begin
          svld_q <= 1'b1;
          sib_q  <= in_byte;
          dlen_q <= dl;
        end
      end
    end
  end

  isp_le_collector #(.NBYTES(DISP_BYTES)) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fresh),
    .we    (accept && !over && state_q == ST_DISP),
    .din   (in_byte),
    .value (disp_val)
  );

  isp_le_collector #(.NBYTES(IMM_BYTES)) u_imm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fresh),
    .we    (accept && !over && state_q == ST_IMM),
    .din   (in_byte),
    .value (imm_val)
  );

  assign in_ready  = rdy_q;
  assign done      = done_q;
  assign abort     = abort_q;
  assign total_len = 4'(len_q);
  assign escaped   = esc_q;
  assign opcode    = op_q;
  assign form_vld  = fvld_q;
  assign form_byte = form_q;
  assign sib_vld   = svld_q;
  assign sib_byte  = sib_q;
  assign disp_len  = dlen_q;
  assign imm_len   = ilen_q;

endmodule

// File: rtl/insn_splitter_chk.sv
module insn_splitter_chk #(
  parameter int MAX_LEN = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       abort,
  input logic [3:0] total_len,
  input logic       form_vld,
  input logic [7:0] form_byte,
  input logic       sib_vld,
  input logic [2:0] disp_len,
  input logic [2:0] imm_len,
  input logic [7:0] mand_pfx,
  input logic       escaped
);

  p_done_abort_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

  p_len_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total_len != 4'd0 && 32'(total_len) <= MAX_LEN));

  p_reg_form_nodisp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && form_vld && form_byte[7:6] == 2'b11) |-> (disp_len == 3'd0 && !sib_vld));

  p_sib_needs_rm4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sib_vld) |-> (form_vld && form_byte[2:0] == 3'b100 && form_byte[7:6] != 2'b11));

  p_imm_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (imm_len == 3'd0 || imm_len == 3'd1 || imm_len == 3'd2 || imm_len == 3'd4));

  p_mand_escape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mand_pfx != 8'h00) |-> escaped);

endmodule

bind insn_splitter insn_splitter_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/insn_splitter_bench.sv
module insn_splitter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        addr32_mode = 1'b1;
  logic        cls_has_form = 1'b0;
  logic [1:0]  cls_imm_code = 2'd0;
  logic        done, abort, dup_err, opsz_ovr, adsz_ovr, escaped, form_vld, sib_vld;
  logic [3:0]  total_len;
  logic [7:0]  rep_lock, seg_ovr, mand_pfx, form_byte, sib_byte;
  logic [15:0] opcode;
  logic [2:0]  disp_len, imm_len;
  logic [31:0] disp_val, imm_val;

  always #5 clk = ~clk;

  insn_splitter u_insn_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .addr32_mode(addr32_mode), .cls_has_form(cls_has_form), .cls_imm_code(cls_imm_code),
    .done(done), .abort(abort), .dup_err(dup_err), .total_len(total_len),
    .rep_lock(rep_lock), .seg_ovr(seg_ovr), .opsz_ovr(opsz_ovr), .adsz_ovr(adsz_ovr),
    .mand_pfx(mand_pfx), .escaped(escaped), .opcode(opcode), .form_vld(form_vld),
    .form_byte(form_byte), .sib_vld(sib_vld), .sib_byte(sib_byte), .disp_len(disp_len),
    .disp_val(disp_val), .imm_len(imm_len), .imm_val(imm_val)
  );

  int vecs = 0;
  int miss = 0;

  logic [7:0]  q [16];
  int          qn;
  logic [7:0]  e_g1, e_g2, e_mand, e_form, e_sib;
  logic        e_g3, e_g4, e_dup, e_esc, e_fv, e_sv;
  logic [15:0] e_op;
  int          e_dlen, e_ilen;
  logic [31:0] e_disp, e_imm;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  function automatic int grp_of(input logic [7:0] b);
    case (b)
      8'hF0, 8'hF2, 8'hF3:                      return 1;
      8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: return 2;
      8'h66:                                    return 3;
      8'h67:                                    return 4;
      default:                                  return 0;
    endcase
  endfunction

  function automatic int disp_rule(input bit wide, input logic [1:0] md,
                                   input logic [2:0] rm, input logic [2:0] base);
    if (md == 2'b11) return 0;
    if (md == 2'b01) return 1;
    if (wide) begin
      if (md == 2'b10) return 4;
      return (rm == 3'b101 || (rm == 3'b100 && base == 3'b101)) ? 4 : 0;
    end
    if (md == 2'b10) return 2;
    return (rm == 3'b110) ? 2 : 0;
  endfunction

  task automatic push(input logic [7:0] b);
    q[qn] = b;
    qn++;
  endtask

  // Builds the byte stream and all expected fields from the chosen parts.
  task automatic build(input bit mode, input logic [31:0] pk, input int np, input bit esc,
                       input logic [7:0] op, input bit hf, input logic [7:0] form,
                       input logic [7:0] sib, input logic [31:0] dval,
                       input logic [1:0] icode, input logic [31:0] ival);
    logic [7:0] lastp;
    bit wide;
    qn = 0; lastp = 8'h00;
    e_g1 = 0; e_g2 = 0; e_g3 = 0; e_g4 = 0; e_dup = 0; e_mand = 0;
    e_esc = esc; e_fv = hf; e_sv = 0; e_form = 0; e_sib = 0;
    e_dlen = 0; e_disp = 0; e_imm = 0;
    for (int i = 0; i < np; i++) begin
      logic [7:0] b;
      b = pk[8*i +: 8];
      push(b);
      case (grp_of(b))
        1: begin if (e_g1 != 0) e_dup = 1; e_g1 = b; end
        2: begin if (e_g2 != 0) e_dup = 1; e_g2 = b; end
        3: begin if (e_g3) e_dup = 1; e_g3 = 1; end
        4: begin if (e_g4) e_dup = 1; e_g4 = 1; end
        default: ;
      endcase
      lastp = b;
    end
    if (esc) begin
      if (lastp == 8'hF2 || lastp == 8'hF3) begin e_mand = lastp; e_g1 = 0; end
      else if (lastp == 8'h66) begin e_mand = lastp; e_g3 = 0; end
      push(8'h0F);
    end
    push(op);
    e_op = esc ? {8'h0F, op} : {8'h00, op};
    e_ilen = (icode == 2'd3) ? 4 : int'(icode);
    if (hf) begin
      wide = mode ^ e_g4;
      push(form);
      e_form = form;
      if (wide && form[7:6] != 2'b11 && form[2:0] == 3'b100) begin
        e_sv = 1; e_sib = sib; push(sib);
      end
      e_dlen = disp_rule(wide, form[7:6], form[2:0], sib[2:0]);
    end
    for (int i = 0; i < e_dlen; i++) begin
      push(dval[8*i +: 8]);
      e_disp[8*i +: 8] = dval[8*i +: 8];
    end
    for (int i = 0; i < e_ilen; i++) begin
      push(ival[8*i +: 8]);
      e_imm[8*i +: 8] = ival[8*i +: 8];
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while ($urandom % 4 == 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
  endtask

  // Sends the built instruction; fields are read in the done cycle while
  // in_valid may already carry the next instruction's first byte.
  task automatic run(input string tag, input bit mode, input bit hf, input logic [1:0] icode);
    addr32_mode  = mode;
    cls_has_form = hf;
    cls_imm_code = icode;
    for (int i = 0; i < qn; i++) begin
      send_byte(q[i]);
      if (i < qn - 1) chk({tag, " R12 done low mid-instruction"}, 32'(done), 32'd0);
    end
    chk({tag, " R12 done pulse"}, 32'(done), 32'd1);
    chk({tag, " R13 no abort"}, 32'(abort), 32'd0);
    chk({tag, " R12 total_len"}, 32'(total_len), 32'(qn));
    chk({tag, " R1 rep_lock"}, 32'(rep_lock), 32'(e_g1));
    chk({tag, " R1 seg_ovr"}, 32'(seg_ovr), 32'(e_g2));
    chk({tag, " R1 opsz_ovr"}, 32'(opsz_ovr), 32'(e_g3));
    chk({tag, " R10 adsz_ovr"}, 32'(adsz_ovr), 32'(e_g4));
    chk({tag, " R2 dup_err"}, 32'(dup_err), 32'(e_dup));
    chk({tag, " R4 mand_pfx"}, 32'(mand_pfx), 32'(e_mand));
    chk({tag, " R3 escaped"}, 32'(escaped), 32'(e_esc));
    chk({tag, " R3 opcode"}, 32'(opcode), 32'(e_op));
    chk({tag, " R6 form"}, {23'd0, form_vld, form_byte}, {23'd0, e_fv, e_form});
    chk({tag, " R7 sib"}, {23'd0, sib_vld, sib_byte}, {23'd0, e_sv, e_sib});
    chk({tag, " R9 disp_len"}, 32'(disp_len), 32'(e_dlen));
    chk({tag, " R11 disp_val"}, disp_val, e_disp);
    chk({tag, " R5 imm_len"}, 32'(imm_len), 32'(e_ilen));
    chk({tag, " R11 imm_val"}, imm_val, e_imm);
  endtask

  task automatic rand_insn();
    bit mode, esc, hf;
    logic [31:0] pk;
    int np, rot;
    logic [7:0] op, segs [6];
    logic [1:0] icode;
    segs = '{8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};
    mode = 1'($urandom);
    np = 0; pk = 0;
    rot = $urandom % 4;
    for (int k = 0; k < 4; k++) begin
      int g;
      g = (k + rot) % 4;
      if ($urandom % 2 == 1) begin
        logic [7:0] b;
        case (g)
          0: b = ($urandom % 3 == 0) ? 8'hF0 : (($urandom % 2 == 1) ? 8'hF2 : 8'hF3);
          1: b = segs[$urandom % 6];
          2: b = 8'h66;
          default: b = 8'h67;
        endcase
        pk[8*np +: 8] = b;
        np++;
      end
    end
    esc = ($urandom % 3 == 0);
    do op = 8'($urandom); while (grp_of(op) != 0 || op == 8'h0F);
    hf = 1'($urandom);
    icode = 2'($urandom);
    if (np == 4 && esc && hf && icode == 2'd3) icode = 2'd2;
    build(mode, pk, np, esc, op, hf, 8'($urandom), 8'($urandom), $urandom, icode, $urandom);
    run("rand R1 R3 R5 R7", mode, hf, icode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R14 ready after reset", 32'(in_ready), 32'd1);
    chk("R12 done idle after reset", 32'(done), 32'd0);
    chk("R13 abort idle after reset", 32'(abort), 32'd0);
    chk("R12 total_len after reset", 32'(total_len), 32'd0);

    // R2: repeated group 1 prefix keeps the later one.
    build(1'b1, 32'h0000_F2F3, 2, 1'b0, 8'h90, 1'b0, 8'h00, 8'h00, 0, 2'd0, 0);
    run("dir R2", 1'b1, 1'b0, 2'd0);
    // R4: 66 just before escape becomes mandatory.
    build(1'b1, 32'h0000_0066, 1, 1'b1, 8'h58, 1'b1, 8'hC1, 8'h00, 0, 2'd0, 0);
    run("dir R4", 1'b1, 1'b1, 2'd0);
    // R4: F3 before escape, F0 earlier is replaced and then moved out.
    build(1'b1, 32'h00F3_2EF0, 3, 1'b1, 8'hE6, 1'b1, 8'hC8, 8'h00, 0, 2'd1, 32'h7F);
    run("dir R4 R2 rep", 1'b1, 1'b1, 2'd1);
    // R10: 67 in 32-bit mode gives 16-bit rules, 06 -> two displacement bytes.
    build(1'b1, 32'h0000_0067, 1, 1'b0, 8'h8B, 1'b1, 8'h06, 8'h00, 32'h1234, 2'd0, 0);
    run("dir R10 R9", 1'b1, 1'b1, 2'd0);
    // R10: next instruction without 67 returns to 32-bit rules.
    build(1'b1, 32'h0, 0, 1'b0, 8'h8B, 1'b1, 8'h04, 8'h25, 32'h1234_5678, 2'd0, 0);
    run("dir R10 R8", 1'b1, 1'b1, 2'd0);
    chk("dir R11 little-endian disp", disp_val, 32'h1234_5678);
    // R9: 16-bit mode, mod 01 and a 2-byte immediate after the displacement.
    build(1'b0, 32'h0, 0, 1'b0, 8'hC7, 1'b1, 8'h46, 8'h00, 32'h10, 2'd2, 32'hBEEF);
    run("dir R9 R11", 1'b0, 1'b1, 2'd2);
    // R8: base 101 with mod 01 is only a 1-byte displacement.
    build(1'b1, 32'h0, 0, 1'b0, 8'h8D, 1'b1, 8'h44, 8'h25, 32'h80, 2'd3, 32'hCAFE_F00D);
    run("dir R8 R11", 1'b1, 1'b1, 2'd3);

    // R13: sixteen prefix bytes overrun the length limit.
    for (int i = 0; i < 16; i++) begin
      send_byte(8'h2E);
      if (i < 15) chk("R13 no abort before 16th byte", 32'(abort), 32'd0);
    end
    chk("R13 abort pulse", 32'(abort), 32'd1);
    chk("R13 no done on overrun", 32'(done), 32'd0);
    build(1'b1, 32'h0, 0, 1'b0, 8'h90, 1'b0, 8'h00, 8'h00, 0, 2'd0, 0);
    run("dir R13 restart", 1'b1, 1'b0, 2'd0);

    for (int n = 0; n < 400; n++) rand_insn();

    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R14 no byte taken while idle", 32'(done), 32'd0);
    summary();
  end

endmodule